// File: doc/BRIEF.md
# Context Validation Tag Generator

This block produces the 8-bit validation byte that sits beside a connection context. It packs a 24-bit connection identifier, a 4-bit region number and a 4-bit context type into one 32-bit word. It runs a CRC-8 over that word, starting from an all-ones seed. The CRC result and a valid marker are then arranged into one of two tag layouts. A caller writes the tag when it sets up a context. When it reads the context back, it supplies the stored byte and gets an indication of whether that byte still matches.

The block also performs the invalidate operation. In that case the supplied byte is returned with its valid marker cleared, and no tag is computed. Each request is taken on a cycle where the input valid is high. The result appears on registered outputs one cycle later, together with an output valid. The region numbers 2 and 4 are the aggregation regions that callers normally tag; the block accepts any region value.

Top module: `ctx_tag_gen`

## Requirements
- R1: While reset is held and on the first cycle after it, outValid, tagOut and matchOut are all 0.
- R2: outValid is high exactly in the cycle after a cycle where inValid was high, and low otherwise.
- R3: With fmtSel=0 and opInv=0, tagOut is {1, crc[6:0]}. Here crc is the remainder of (0xFF·x^32 + W·x^8) modulo x^8+x^2+x+1, and W = {connId, region, kind}, with connId in bits 31:8, region in bits 7:4 and kind in bits 3:0, most significant bit first.
- R4: With fmtSel=1 and opInv=0, tagOut is {1, kind[3:0], crc[2:0]}, using the same crc as R3.
- R5: With opInv=1, tagOut equals storedTag with bit 7 cleared and bits 6:0 unchanged, and matchOut is 0. fmtSel, connId, region and kind have no effect on either output.
- R6: With opInv=0, matchOut is 1 exactly when storedTag equals the tag computed for the same inputs and mode.
- R7: In a cycle where inValid is low, tagOut and matchOut keep their previous values.
- R8: Every computed tag (opInv=0) has bit 7 set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| connId | input | 24 | Connection identifier |
| region | input | 4 | Region number |
| kind | input | 4 | Context type |
| fmtSel | input | 1 | 0: type-A layout, 1: type-B layout |
| opInv | input | 1 | 1: invalidate storedTag instead of computing |
| storedTag | input | 8 | Byte to compare, or byte to invalidate |
| outValid | output | 1 | Result strobe, one cycle after inValid |
| tagOut | output | 8 | Computed or invalidated tag |
| matchOut | output | 1 | storedTag equals the computed tag |

## Verification
The bench sweeps every region and type value in both layouts over a set of connection IDs with all-zero, all-one and alternating bit patterns. A wrong seed, a reversed bit order or a misplaced field would show up as a wrong tag on most of these vectors. Every possible stored byte is run through the invalidate path with the mode and identifier inputs varied, which catches a marker that is left set, a mask that also clears bit 6, or a mode input leaking into that path. The match output is checked with the exact expected byte and with a byte that differs only in its top bit. This exposes a compare that skips the marker, and outputs that drift during idle cycles are caught by the hold checks.

// File: rtl/ctx_tag_pkg.sv
package ctx_tag_pkg;
  localparam int ID_W   = 24;
  localparam int REG_W  = 4;
  localparam int KIND_W = 4;
  localparam int TAG_W  = 8;
  localparam logic [TAG_W-1:0] CRC_POLY = 8'h07;
  localparam logic [TAG_W-1:0] CRC_SEED = 8'hFF;
  // aggregation regions normally tagged by callers
  localparam logic [REG_W-1:0] REGION_AGG_X = 4'd2;
  localparam logic [REG_W-1:0] REGION_AGG_U = 4'd4;

  typedef struct packed {
    logic capture;
    logic invalidate;
    logic fmtB;
  } tagStrobe_t;
endpackage

// File: rtl/ctx_tag_ctrl.sv
module ctx_tag_ctrl
  import ctx_tag_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       opInv,
  input  logic       fmtSel,
  output tagStrobe_t strobe,
  output logic       outValid
);
  always_comb begin
    strobe.capture    = inValid;
    strobe.invalidate = inValid & opInv;
    strobe.fmtB       = fmtSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/ctx_tag_dp.sv
module ctx_tag_dp
  import ctx_tag_pkg::*;
#(
  parameter int IdW   = ID_W,
  parameter int RegW  = REG_W,
  parameter int KindW = KIND_W,
  parameter int TagW  = TAG_W,
  parameter logic [TagW-1:0] Poly = CRC_POLY,
  parameter logic [TagW-1:0] Seed = CRC_SEED
)(
  input  logic             clk,
  input  logic             rstN,
  input  tagStrobe_t       strobe,
  input  logic [IdW-1:0]   connId,
  input  logic [RegW-1:0]  region,
  input  logic [KindW-1:0] kind,
  input  logic [TagW-1:0]  storedTag,
  output logic [TagW-1:0]  tagOut,
  output logic             matchOut
);
  localparam int WordW = IdW + RegW + KindW;
  localparam int LowW  = TagW - 1 - KindW;

  function automatic logic [TagW-1:0] crcWord(input logic [WordW-1:0] w);
    logic [TagW-1:0] c;
    logic fb;
    c = Seed;
    for (int i = WordW - 1; i >= 0; i--) begin
      fb = c[TagW-1] ^ w[i];
      c  = {c[TagW-2:0], 1'b0} ^ (fb ? Poly : '0);
    end
    return c;
  endfunction

  logic [WordW-1:0] packedWord;
  logic [TagW-1:0]  crcVal;
  logic [TagW-1:0]  tagA;
  logic [TagW-1:0]  tagB;
  logic [TagW-1:0]  computed;

  always_comb begin
    packedWord = {connId, region, kind};
    crcVal     = crcWord(packedWord);
    tagA       = {1'b1, crcVal[TagW-2:0]};
    tagB       = {1'b1, kind, crcVal[LowW-1:0]};
    computed   = strobe.fmtB ? tagB : tagA;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tagOut   <= '0;
      matchOut <= 1'b0;
    end else if (strobe.capture) begin
      if (strobe.invalidate) begin
        tagOut   <= {1'b0, storedTag[TagW-2:0]};
        matchOut <= 1'b0;
      end else begin
        tagOut   <= computed;
        matchOut <= (storedTag == computed);
      end
    end
  end
endmodule

// File: rtl/ctx_tag_gen.sv
module ctx_tag_gen
  import ctx_tag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [ID_W-1:0]   connId,
  input  logic [REG_W-1:0]  region,
  input  logic [KIND_W-1:0] kind,
  input  logic              fmtSel,
  input  logic              opInv,
  input  logic [TAG_W-1:0]  storedTag,
  output logic              outValid,
  output logic [TAG_W-1:0]  tagOut,
  output logic              matchOut
);
  tagStrobe_t strobe;

  ctx_tag_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opInv(opInv),
    .fmtSel(fmtSel), .strobe(strobe), .outValid(outValid)
  );

  ctx_tag_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .connId(connId),
    .region(region), .kind(kind), .storedTag(storedTag),
    .tagOut(tagOut), .matchOut(matchOut)
  );
endmodule

// File: rtl/ctx_tag_gen_chk.sv
module ctx_tag_gen_chk
  import ctx_tag_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              opInv,
  input logic              fmtSel,
  input logic [KIND_W-1:0] kind,
  input logic [TAG_W-1:0]  storedTag,
  input logic              outValid,
  input logic [TAG_W-1:0]  tagOut,
  input logic              matchOut
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R2
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(tagOut) && $stable(matchOut))); // R7
  AST_INVALIDATE: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opInv) |=> (tagOut == {1'b0, $past(storedTag[TAG_W-2:0])} && !matchOut)); // R5
  AST_MARKER_SET: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !opInv) |=> tagOut[TAG_W-1]); // R8
  AST_TYPEB_FIELD: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !opInv && fmtSel) |=> (tagOut[TAG_W-2 -: KIND_W] == $past(kind))); // R4
  AST_MATCH_EQ: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !opInv) |=> (matchOut == (tagOut == $past(storedTag)))); // R6
endmodule

bind ctx_tag_gen ctx_tag_gen_chk u_chk (.*);

// File: tb/tb_ctx_tag_gen.sv
module tb_ctx_tag_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [23:0] connId = '0;
  logic [3:0]  region = '0;
  logic [3:0]  kind = '0;
  logic        fmtSel = 1'b0;
  logic        opInv = 1'b0;
  logic [7:0]  storedTag = '0;
  logic        outValid;
  logic [7:0]  tagOut;
  logic        matchOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ctx_tag_gen dut (.*);

  // remainder of (FF * x^32 + W * x^8) mod 0x107, by long division
  function automatic logic [7:0] refCrc(input logic [31:0] w);
    logic [39:0] v;
    v = {8'hFF, 32'h0} ^ {w, 8'h0};
    for (int i = 39; i >= 8; i--)
      if (v[i]) v = v ^ (40'h107 << (i - 8));
    return v[7:0];
  endfunction

  function automatic logic [7:0] refTag(input logic [23:0] id, input logic [3:0] rg,
                                        input logic [3:0] kd, input logic b);
    logic [7:0] c;
    c = refCrc({id, rg, kd});
    return b ? {1'b1, kd, c[2:0]} : {1'b1, c[6:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, captured at next posedge, checked at following negedge
  task automatic issue(input logic [23:0] id, input logic [3:0] rg, input logic [3:0] kd,
                       input logic b, input logic inv, input logic [7:0] st);
    inValid = 1'b1; connId = id; region = rg; kind = kd;
    fmtSel = b; opInv = inv; storedTag = st;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    logic [23:0] ids [6];
    logic [7:0]  exp;
    logic [7:0]  holdTag;
    logic        holdMatch;
    ids = '{24'h000000, 24'hFFFFFF, 24'hAAAAAA, 24'h555555, 24'h123456, 24'h800001};

    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 outValid in reset", outValid, 0);
    check("R1 tagOut in reset", tagOut, 0);
    check("R1 matchOut in reset", matchOut, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 tagOut after reset", tagOut, 0);
    check("R2 outValid idle", outValid, 0);

    // R3 R4 R6 R8 sweep
    for (int n = 0; n < 6; n++)
      for (int r = 0; r < 16; r++)
        for (int k = 0; k < 16; k++)
          for (int m = 0; m < 2; m++) begin
            exp = refTag(ids[n], 4'(r), 4'(k), m[0]);
            issue(ids[n], 4'(r), 4'(k), m[0], 1'b0, ((r + k) % 2 == 0) ? exp : (exp ^ 8'h80));
            check("R2 outValid after request", outValid, 1);
            check(m[0] ? "R4 type-B tag" : "R3 type-A tag", tagOut, exp);
            check("R8 marker bit", tagOut[7], 1);
            check("R6 match", matchOut, ((r + k) % 2 == 0) ? 1 : 0);
          end

    // R6 on the aggregation regions, one-bit mismatch in low bits
    exp = refTag(24'h00ABCD, 4'd2, 4'd7, 1'b0);
    issue(24'h00ABCD, 4'd2, 4'd7, 1'b0, 1'b0, exp ^ 8'h01);
    check("R6 mismatch low bit", matchOut, 0);
    exp = refTag(24'h00ABCD, 4'd4, 4'd7, 1'b1);
    issue(24'h00ABCD, 4'd4, 4'd7, 1'b1, 1'b0, exp);
    check("R6 match region 4", matchOut, 1);

    // R5 invalidate sweep over all stored bytes
    for (int s = 0; s < 256; s++) begin
      issue(ids[s % 6], 4'(s), 4'(s >> 4), s[0], 1'b1, 8'(s));
      check("R5 invalidate tag", tagOut, {1'b0, 7'(s)});
      check("R5 invalidate match", matchOut, 0);
      check("R2 outValid invalidate", outValid, 1);
    end

    // R7 hold while idle with changing inputs
    exp = refTag(24'h0F0F0F, 4'd9, 4'd3, 1'b0);
    issue(24'h0F0F0F, 4'd9, 4'd3, 1'b0, 1'b0, exp);
    holdTag = tagOut; holdMatch = matchOut;
    for (int c = 0; c < 8; c++) begin
      connId = 24'(c * 977); region = 4'(c); kind = 4'(c + 5);
      storedTag = 8'(c * 31); opInv = c[0]; fmtSel = c[1];
      @(negedge clk);
      check("R7 tag hold", tagOut, holdTag);
      check("R7 match hold", matchOut, holdMatch);
      check("R2 outValid low when idle", outValid, 0);
    end

    // R1 reset again mid-stream
    issue(24'h1, 4'd1, 4'd1, 1'b0, 1'b0, 8'h00);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 tag cleared by reset", tagOut, 0);
    check("R1 outValid cleared by reset", outValid, 0);
    rstN = 1'b1;
    @(negedge clk);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    #1500000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule